// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data between them in either direction. Each direction has its own storage bank. A bank either follows its source bus or holds a value it captured earlier. The value the bank presents can be put onto the opposite bus under an output enable. A direction has three active-low controls: a direction gate, a latch gate and an output gate. The two directions share no control.

Each bus pad is modelled as three vectors: an input, an output and a per-bit output enable. The surrounding logic resolves the real bus from these. A build parameter chooses between two variants. In the pass-through variant the driven value equals the stored value. In the inverting variant it is the complement, in both directions.

The block runs in a synchronous style with an asynchronous active-low reset. While a bank is open, its output follows the source input in the same cycle. The bank is written at every clock edge at which it is open. When the bank closes, it therefore keeps the value sampled at the last edge at which it was open.

Top module: `xcvrLatched`

## Requirements
- R1: The A-to-B and B-to-A paths are independent. Activity on one direction's controls or source bus never changes what the other direction stores or drives. All bits of a direction share that direction's controls.
- R2: A bank is open when its direction gate and its latch gate are both 0. While it is open, its destination output equals its source input in the same cycle (complemented when INVERT=1).
- R3: If the latch gate rises to 1 while the direction gate stays 0, the bank closes. It keeps the source value present in the last cycle it was open.
- R4: If the direction gate rises to 1 while the latch gate is 0, the bank also closes. It keeps the source value from the last cycle it was open, and that value is shown once the direction is enabled again with the latch gate at 1.
- R5: While a bank is closed, changes on its source bus do not alter the stored or driven value.
- R6: All bits of a destination output enable are 1 when both the output gate and the direction gate are 0. Otherwise all of them are 0.
- R7: A bank loads even while its output gate is 1. The loaded value appears on the destination once the output gate goes to 0.
- R8: With INVERT=1 every driven bit is the complement of the stored or transparent bit. With INVERT=0 it is equal to that bit.
- R9: An active-low asynchronous reset clears both banks to all zeros.
- R10: `busClash` is 1 exactly when both ports are driving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which the banks sample |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | WIDTH | Value seen on bus A |
| aOut | output | WIDTH | Value offered to bus A (B-to-A path) |
| aOe | output | WIDTH | Per-bit drive enable for bus A |
| bIn | input | WIDTH | Value seen on bus B |
| bOut | output | WIDTH | Value offered to bus B (A-to-B path) |
| bOe | output | WIDTH | Per-bit drive enable for bus B |
| abDirN | input | 1 | A-to-B direction gate, active low |
| abLatchN | input | 1 | A-to-B latch gate, active low |
| abOutN | input | 1 | A-to-B output gate, active low |
| baDirN | input | 1 | B-to-A direction gate, active low |
| baLatchN | input | 1 | B-to-A latch gate, active low |
| baOutN | input | 1 | B-to-A output gate, active low |
| busClash | output | 1 | Both ports driving at once |

## Verification
The bench closes a bank in two ways: through the latch gate, and through the direction gate while the latch gate stays low. It then changes the source. A design that closes only on the latch gate would keep following the source in the second case, or would show the wrong captured word. The bench loads a bank with its outputs off and enables them later; a design that ties loading to driving would show stale data there. While one bank holds a value, the bench drives the other direction transparently, which exposes any cross-coupling and sets off the clash flag. Every case runs on both the pass-through and the inverting variant, so a missing or one-sided complement shows up on the resolved bus values.

// File: rtl/xcvrPkg.sv
package xcvrPkg;
  // strobes sent from the control decode to the storage banks
  typedef struct packed {
    logic abOpen;
    logic abDrive;
    logic baOpen;
    logic baDrive;
    logic clash;
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import xcvrPkg::*;
(
  input  logic        abDirN,
  input  logic        abLatchN,
  input  logic        abOutN,
  input  logic        baDirN,
  input  logic        baLatchN,
  input  logic        baOutN,
  output xcvrStrobe_t strobe
);
  logic abDrv;
  logic baDrv;

  // the direction gate qualifies both the bank opening and the drive
  assign abDrv = ~abDirN & ~abOutN;
  assign baDrv = ~baDirN & ~baOutN;

  always_comb begin
    strobe.abOpen  = ~abDirN & ~abLatchN;
    strobe.abDrive = abDrv;
    strobe.baOpen  = ~baDirN & ~baLatchN;
    strobe.baDrive = baDrv;
    strobe.clash   = abDrv & baDrv;
  end
endmodule

// File: rtl/xcvrBank.sv
module xcvrBank #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             open,
  input  logic             drive,
  input  logic [WIDTH-1:0] srcIn,
  output logic [WIDTH-1:0] dstOut,
  output logic [WIDTH-1:0] dstOe
);
  logic [WIDTH-1:0] held;
  logic [WIDTH-1:0] view;

  // written at every edge while open, so closing keeps the last open sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     held <= '0;
    else if (open) held <= srcIn;
  end

  // same-cycle pass-through while open
  assign view = open ? srcIn : held;

  generate
    if (INVERT) begin : g_invert
      assign dstOut = ~view;
    end else begin : g_pass
      assign dstOut = view;
    end
  endgenerate

  assign dstOe = {WIDTH{drive}};
endmodule

// File: rtl/xcvrLatched.sv
module xcvrLatched
  import xcvrPkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe,
  input  logic             abDirN,
  input  logic             abLatchN,
  input  logic             abOutN,
  input  logic             baDirN,
  input  logic             baLatchN,
  input  logic             baOutN,
  output logic             busClash
);
  xcvrStrobe_t strobe;

  xcvrCtrl u_ctrl (
    .abDirN  (abDirN),
    .abLatchN(abLatchN),
    .abOutN  (abOutN),
    .baDirN  (baDirN),
    .baLatchN(baLatchN),
    .baOutN  (baOutN),
    .strobe  (strobe)
  );

  xcvrBank #(.WIDTH(WIDTH), .INVERT(INVERT)) u_abBank (
    .clk   (clk),
    .rstN  (rstN),
    .open  (strobe.abOpen),
    .drive (strobe.abDrive),
    .srcIn (aIn),
    .dstOut(bOut),
    .dstOe (bOe)
  );

  xcvrBank #(.WIDTH(WIDTH), .INVERT(INVERT)) u_baBank (
    .clk   (clk),
    .rstN  (rstN),
    .open  (strobe.baOpen),
    .drive (strobe.baDrive),
    .srcIn (bIn),
    .dstOut(aOut),
    .dstOe (aOe)
  );

  assign busClash = strobe.clash;
endmodule

// File: rtl/xcvrLatchedChecker.sv
module xcvrLatchedChecker #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] aOe,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic [WIDTH-1:0] bOe,
  input logic             abDirN,
  input logic             abLatchN,
  input logic             abOutN,
  input logic             baDirN,
  input logic             baLatchN,
  input logic             baOutN,
  input logic             busClash
);
  localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  // R2 / R8: transparent path follows the source in the same cycle
  assert_ab_transparent_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!abDirN && !abLatchN) |-> (bOut == (aIn ^ FLIP)));
  assert_ba_transparent_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!baDirN && !baLatchN) |-> (aOut == (bIn ^ FLIP)));

  // R3: closing by the latch gate keeps the last open sample
  assert_ab_close_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!abDirN && abLatchN && $past(!abDirN && !abLatchN)) |-> (bOut == ($past(aIn) ^ FLIP)));
  assert_ba_close_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!baDirN && baLatchN && $past(!baDirN && !baLatchN)) |-> (aOut == ($past(bIn) ^ FLIP)));

  // R5: a closed bank shown with its direction enabled does not move
  assert_ab_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!abDirN && abLatchN && $past(!abDirN && abLatchN)) |-> $stable(bOut));
  assert_ba_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!baDirN && baLatchN && $past(!baDirN && baLatchN)) |-> $stable(aOut));

  // R6: drive gating
  assert_b_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (abOutN || abDirN) |-> (bOe == '0));
  assert_b_on_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!abOutN && !abDirN) |-> (&bOe));
  assert_a_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (baOutN || baDirN) |-> (aOe == '0));

  // R10: clash flag matches both ports driving
  assert_clash_R10: assert property (@(posedge clk) disable iff (!rstN)
    busClash == ((|aOe) && (|bOe)));
endmodule

bind xcvrLatched xcvrLatchedChecker #(.WIDTH(WIDTH), .INVERT(INVERT)) u_checker (
  .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
  .bIn(bIn), .bOut(bOut), .bOe(bOe),
  .abDirN(abDirN), .abLatchN(abLatchN), .abOutN(abOutN),
  .baDirN(baDirN), .baLatchN(baLatchN), .baOutN(baOutN),
  .busClash(busClash)
);

// File: tb/xcvrLatched_bench.sv
module xcvrLatched_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic abDirN = 1'b1, abLatchN = 1'b1, abOutN = 1'b1;
  logic baDirN = 1'b1, baLatchN = 1'b1, baOutN = 1'b1;

  logic [W-1:0] aOut, aOe, bOut, bOe;
  logic [W-1:0] aOutI, aOeI, bOutI, bOeI;
  logic clash, clashI;

  int runCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  xcvrLatched #(.WIDTH(W), .INVERT(1'b0)) u_xcvrLatched (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .abDirN(abDirN), .abLatchN(abLatchN), .abOutN(abOutN),
    .baDirN(baDirN), .baLatchN(baLatchN), .baOutN(baOutN),
    .busClash(clash));

  xcvrLatched #(.WIDTH(W), .INVERT(1'b1)) u_xcvrLatchedInv (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOutI), .aOe(aOeI),
    .bIn(bIn), .bOut(bOutI), .bOe(bOeI),
    .abDirN(abDirN), .abLatchN(abLatchN), .abOutN(abOutN),
    .baDirN(baDirN), .baLatchN(baLatchN), .baOutN(baOutN),
    .busClash(clashI));

  typedef struct {
    logic [W-1:0] aRd;
    logic [W-1:0] bRd;
    logic [W-1:0] aRdI;
    logic [W-1:0] bRdI;
    logic         clash;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [W-1:0] modelAb = '0;
  logic [W-1:0] modelBa = '0;

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues what the buses must read
  task automatic step(input logic abD, input logic abL, input logic abO,
                      input logic baD, input logic baL, input logic baO,
                      input logic [W-1:0] av, input logic [W-1:0] bv, input string tag);
    expItem_t e;
    logic abOpen, baOpen, abDrv, baDrv;
    logic [W-1:0] abView, baView;
    @(negedge clk);
    abDirN = abD; abLatchN = abL; abOutN = abO;
    baDirN = baD; baLatchN = baL; baOutN = baO;
    aIn = av; bIn = bv;
    abOpen = !abD && !abL;  baOpen = !baD && !baL;
    abDrv  = !abD && !abO;  baDrv  = !baD && !baO;
    abView = abOpen ? av : modelAb;
    baView = baOpen ? bv : modelBa;
    e.bRd   = abDrv ? abView  : bv;
    e.bRdI  = abDrv ? ~abView : bv;
    e.aRd   = baDrv ? baView  : av;
    e.aRdI  = baDrv ? ~baView : av;
    e.clash = abDrv && baDrv;
    e.tag   = tag;
    expQ.push_back(e);
    if (abOpen) modelAb = av;
    if (baOpen) modelBa = bv;
  endtask

  // monitor: resolves the buses away from the clock edge and compares
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        expItem_t e;
        logic [W-1:0] aRd, bRd, aRdI, bRdI;
        e = expQ.pop_front();
        aRd  = (aOe  & aOut)  | (~aOe  & aIn);
        bRd  = (bOe  & bOut)  | (~bOe  & bIn);
        aRdI = (aOeI & aOutI) | (~aOeI & aIn);
        bRdI = (bOeI & bOutI) | (~bOeI & bIn);
        check(e.tag, "busA", aRd, e.aRd);
        check(e.tag, "busB", bRd, e.bRd);
        check(e.tag, "clash", {7'd0, clash}, {7'd0, e.clash});
        check({"R8 ", e.tag}, "busA inv", aRdI, e.aRdI);
        check({"R8 ", e.tag}, "busB inv", bRdI, e.bRdI);
        check({"R10 ", e.tag}, "clash inv", {7'd0, clashI}, {7'd0, e.clash});
      end
    end
  end

  initial begin
    #(8 * 200000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: idle after reset, nothing driven; then cleared banks shown
    step(1,1,1, 1,1,1, 8'h12, 8'h34, "R9 idle");
    step(0,1,0, 1,1,1, 8'hA5, 8'h00, "R9 ab cleared");
    step(1,1,1, 0,1,0, 8'h00, 8'h5C, "R9 ba cleared");
    // R2: A-to-B transparency
    step(0,0,0, 1,1,1, 8'h5A, 8'h00, "R2 ab follow");
    step(0,0,0, 1,1,1, 8'hC3, 8'h00, "R2 ab follow");
    // R3 / R5: close by latch gate, then source changes ignored
    step(0,1,0, 1,1,1, 8'h99, 8'h00, "R3 ab latch close");
    step(0,1,0, 1,1,1, 8'h11, 8'h00, "R5 ab hold");
    step(0,1,0, 1,1,1, 8'hEE, 8'h00, "R5 ab hold");
    // R4: close by direction gate with latch gate still low
    step(0,0,0, 1,1,1, 8'h3C, 8'h00, "R4 ab open");
    step(1,0,0, 1,1,1, 8'h77, 8'h21, "R4 ab dir close");
    step(1,1,0, 1,1,1, 8'h55, 8'h21, "R4 ab parked");
    step(0,1,0, 1,1,1, 8'h66, 8'h21, "R4 ab shown");
    // R6: drive gating
    step(0,1,1, 1,1,1, 8'h66, 8'h0F, "R6 out gate high");
    step(1,1,0, 1,1,1, 8'h66, 8'hF0, "R6 dir gate high");
    // R7: load while outputs off, show later
    step(0,0,1, 1,1,1, 8'hE7, 8'h42, "R7 load hidden");
    step(0,1,1, 1,1,1, 8'h00, 8'h42, "R7 closed hidden");
    step(0,1,0, 1,1,1, 8'h00, 8'h42, "R7 revealed");
    step(1,1,1, 1,1,1, 8'h00, 8'h42, "R6 park");
    // B-to-A direction
    step(1,1,1, 0,0,0, 8'h81, 8'h6B, "R2 ba follow");
    step(1,1,1, 0,1,0, 8'h81, 8'hF0, "R3 ba latch close");
    step(1,1,1, 0,1,0, 8'h81, 8'h0D, "R5 ba hold");
    step(1,1,1, 0,0,0, 8'h81, 8'h2D, "R4 ba open");
    step(1,1,1, 1,0,0, 8'h81, 8'hB4, "R4 ba dir close");
    step(1,1,1, 1,1,0, 8'h81, 8'hB5, "R4 ba parked");
    step(1,1,1, 0,1,0, 8'h81, 8'hB6, "R4 ba shown");
    // R1 / R10: both ports driven, directions stay independent
    step(0,1,0, 0,0,0, 8'h13, 8'hC8, "R1 both drive");
    step(0,1,0, 0,0,0, 8'h24, 8'h9E, "R10 clash");
    step(0,1,0, 1,1,1, 8'h35, 8'h9E, "R10 clash clear");
    step(1,1,1, 0,1,0, 8'h46, 8'h00, "R1 ba kept");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule